// File: doc/BRIEF.md
# Keyed Windowed Watchdog

This block watches over running software. A 32-bit count goes up by one each time the processor fetches an instruction, as signalled by a fetch strobe. Software has to restart the count before it reaches a configured limit. If the count reaches the limit, or if software tries to restart it the wrong way, a sticky event output goes high and stays high until reset. The event is meant to drive a non-maskable trap.

A restart takes two keyed writes in order. First an arming key goes to one register, then a fire key goes to a second register. The fire key is only accepted once the count has reached a configured window threshold, so a restart that comes too early counts as a fault. Each kind of misuse sets its own sticky flag, and either flag raises the event after a fixed delay. A small register port gives access to control, the two keys, status, the count, a hold register for the upper half of the count, and read-back of both configured values.

Top module: `keyed_window_wdt`

## Requirements
- R1: While enabled, the count rises by exactly one on each clock edge that samples `fetch_stb` high, and holds on every other edge. Reading address 4 returns count bits 15:0 and address 5 returns bits 31:16.
- R2: When the enabled count equals `cfg_max_cnt`, `evt_o` rises on the next edge and the count stops at that value.
- R3: With `cfg_force_on` high the block runs and control bit 0 (address 0) reads 1. Otherwise, writing 1 to control bit 0 turns the block on, and a later write of 0 leaves it on. While the block is off, the count holds and key writes are ignored.
- R4: `win_open_o` and status bit 3 are 1 exactly when the count is greater than or equal to `cfg_win_thr`, including the case where the count equals the threshold.
- R5: Writing any value other than 0x40 to the arming key (address 1, bits 7:0) sets the arming-fault flag (`bad_pre_o`, status bit 0).
- R6: Writing the fire key (address 2) when no valid arming write came before it sets the arming-fault flag.
- R7: Once armed, each of these sets the fire-fault flag (`bad_clr_o`, status bit 1): a fire value other than 0x08, a correct fire key while the window is closed, or a second 0x40 arming write.
- R8: An arming write of 0x40 followed by a fire write of 0x08 while the window is open sets the count to zero and sets both key registers to zero on read-back.
- R9: Both fault flags and `evt_o` (status bit 2) are sticky until reset, and either fault flag raises `evt_o`.
- R10: Once `evt_o` is set, the count no longer changes, whether strobes arrive or a valid restart sequence is written.
- R11: A faulty key write sampled at edge k sets its fault flag at edge k+1 and `evt_o` at edge k+2.
- R12: Reading address 4 or 5 copies count bits 31:16 into the hold register (address 6). The hold register resets to 0 and changes on no other event.
- R13: Addresses 7 and 8 return the low and high halves of `cfg_max_cnt`, and addresses 9 and 10 return the low and high halves of `cfg_win_thr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_stb | input | 1 | One pulse per instruction fetch |
| cfg_force_on | input | 1 | Configuration force-enable |
| cfg_max_cnt | input | 32 | Count at which the event fires |
| cfg_win_thr | input | 32 | Count at which the restart window opens |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| evt_o | output | 1 | Sticky watchdog event |
| bad_pre_o | output | 1 | Sticky arming-fault flag |
| bad_clr_o | output | 1 | Sticky fire-fault flag |
| win_open_o | output | 1 | Restart window open |

## Verification
The bench checks the window at one count below the threshold and at exactly the threshold. A design that compared with the wrong relational operator would either reject a valid restart or accept an early one. Each misuse path (a wrong arming value, a fire with no arming, a wrong fire value, a fire outside the window, a double arm) is checked to raise only its own flag. A design with the flags swapped, or with no detection of the double arm, shows the wrong status. The fault-to-event latency is checked edge by edge, and the count is checked to stay frozen after expiry and after a fault, so that a design which kept counting or restarted after an event is caught. The hold register is checked with a count above 0xFFFF, because a snapshot of the wrong half only shows up there.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   typedef enum logic [3:0] {
      A_CTRL = 4'd0,
      A_ARM  = 4'd1,
      A_FIRE = 4'd2,
      A_STAT = 4'd3,
      A_CNTL = 4'd4,
      A_CNTH = 4'd5,
      A_HOLD = 4'd6,
      A_MAXL = 4'd7,
      A_MAXH = 4'd8,
      A_WINL = 4'd9,
      A_WINH = 4'd10
   } wdt_addr_e;

   localparam int ST_BAD_PRE = 0;
   localparam int ST_BAD_CLR = 1;
   localparam int ST_EVT     = 2;
   localparam int ST_WIN     = 3;
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          zero,
   input  logic [CW-1:0] max_cnt,
   input  logic [CW-1:0] win_thr,
   output logic [CW-1:0] cnt,
   output logic          at_max,
   output logic          win_open
);
   assign at_max   = (cnt == max_cnt);
   assign win_open = (cnt >= win_thr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (zero)
         cnt <= '0;
      else if (step && !at_max)
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq #(
   parameter int          KW       = 8,
   parameter int          BAD_DLY  = 2,
   parameter logic [7:0]  KEY_ARM  = 8'h40,
   parameter logic [7:0]  KEY_FIRE = 8'h08
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm_we,
   input  logic          fire_we,
   input  logic [KW-1:0] wdata,
   input  logic          win_open,
   output logic          fire_ok,
   output logic [KW-1:0] arm_key,
   output logic [KW-1:0] fire_key,
   output logic          bad_pre,
   output logic          bad_clr
);
   logic armed_q;
   logic err_pre, err_clr;
   logic dly_pre, dly_clr;

   always_comb begin
      err_pre = 1'b0;
      err_clr = 1'b0;
      fire_ok = 1'b0;
      if (arm_we) begin
         if (wdata != KW'(KEY_ARM))
            err_pre = 1'b1;
         else if (armed_q)
            err_clr = 1'b1;
      end else if (fire_we) begin
         if (!armed_q)
            err_pre = 1'b1;
         else if ((wdata != KW'(KEY_FIRE)) || !win_open)
            err_clr = 1'b1;
         else
            fire_ok = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q  <= 1'b0;
         arm_key  <= '0;
         fire_key <= '0;
      end else if (fire_ok) begin
         armed_q  <= 1'b0;
         arm_key  <= '0;
         fire_key <= '0;
      end else if (arm_we) begin
         arm_key  <= wdata;
         armed_q  <= armed_q | (wdata == KW'(KEY_ARM));
      end else if (fire_we) begin
         fire_key <= wdata;
      end
   end

   generate
      if (BAD_DLY == 2) begin : g_dly_short
         logic p_pre, p_clr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               p_pre <= 1'b0;
               p_clr <= 1'b0;
            end else begin
               p_pre <= err_pre;
               p_clr <= err_clr;
            end
         end
         assign dly_pre = p_pre;
         assign dly_clr = p_clr;
      end else begin : g_dly_long
         logic [BAD_DLY-2:0] s_pre, s_clr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s_pre <= '0;
               s_clr <= '0;
            end else begin
               s_pre <= {s_pre[BAD_DLY-3:0], err_pre};
               s_clr <= {s_clr[BAD_DLY-3:0], err_clr};
            end
         end
         assign dly_pre = s_pre[BAD_DLY-2];
         assign dly_clr = s_clr[BAD_DLY-2];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bad_pre <= 1'b0;
         bad_clr <= 1'b0;
      end else begin
         bad_pre <= bad_pre | dly_pre;
         bad_clr <= bad_clr | dly_clr;
      end
   end
endmodule

// File: rtl/wdt_regif.sv
module wdt_regif
   import wdt_pkg::*;
#(
   parameter int DW = 16,
   parameter int CW = 32,
   parameter int KW = 8,
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic          re,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic          force_on,
   input  logic [CW-1:0] cnt,
   input  logic [CW-1:0] max_cnt,
   input  logic [CW-1:0] win_thr,
   input  logic [KW-1:0] arm_key,
   input  logic [KW-1:0] fire_key,
   input  logic [3:0]    status,
   output logic [DW-1:0] rdata,
   output logic          enabled,
   output logic          arm_we,
   output logic          fire_we
);
   localparam int HW = CW - DW;

   logic          sw_on_q;
   logic [HW-1:0] hold_q;
   logic          cnt_rd;

   assign enabled = force_on | sw_on_q;
   assign arm_we  = we && enabled && (addr == AW'(A_ARM));
   assign fire_we = we && enabled && (addr == AW'(A_FIRE));
   assign cnt_rd  = re && ((addr == AW'(A_CNTL)) || (addr == AW'(A_CNTH)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sw_on_q <= 1'b0;
      else if (we && (addr == AW'(A_CTRL)) && wdata[0])
         sw_on_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hold_q <= '0;
      else if (cnt_rd)
         hold_q <= cnt[CW-1:DW];
   end

   always_comb begin
      rdata = '0;
      case (addr)
         AW'(A_CTRL): rdata[0]       = enabled;
         AW'(A_ARM):  rdata[KW-1:0]  = arm_key;
         AW'(A_FIRE): rdata[KW-1:0]  = fire_key;
         AW'(A_STAT): rdata[3:0]     = status;
         AW'(A_CNTL): rdata          = cnt[DW-1:0];
         AW'(A_CNTH): rdata[HW-1:0]  = cnt[CW-1:DW];
         AW'(A_HOLD): rdata[HW-1:0]  = hold_q;
         AW'(A_MAXL): rdata          = max_cnt[DW-1:0];
         AW'(A_MAXH): rdata[HW-1:0]  = max_cnt[CW-1:DW];
         AW'(A_WINL): rdata          = win_thr[DW-1:0];
         AW'(A_WINH): rdata[HW-1:0]  = win_thr[CW-1:DW];
         default:     rdata          = '0;
      endcase
   end
endmodule

// File: rtl/keyed_window_wdt.sv
module keyed_window_wdt
   import wdt_pkg::*;
#(
   parameter int         CW       = 32,
   parameter int         DW       = 16,
   parameter int         KW       = 8,
   parameter int         AW       = 4,
   parameter int         BAD_DLY  = 2,
   parameter logic [7:0] KEY_ARM  = 8'h40,
   parameter logic [7:0] KEY_FIRE = 8'h08
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fetch_stb,
   input  logic          cfg_force_on,
   input  logic [CW-1:0] cfg_max_cnt,
   input  logic [CW-1:0] cfg_win_thr,
   input  logic          reg_we,
   input  logic          reg_re,
   input  logic [AW-1:0] reg_addr,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   output logic          evt_o,
   output logic          bad_pre_o,
   output logic          bad_clr_o,
   output logic          win_open_o
);
   generate
      if (CW != 2 * DW) begin : g_bad_cw
         $error("counter width must be twice the data width");
      end
      if (KW > DW || KW > 8) begin : g_bad_kw
         $error("key width must fit in the data word and in 8 bits");
      end
      if (BAD_DLY < 2) begin : g_bad_dly
         $error("fault latency must be at least two edges");
      end
      if (AW < 4) begin : g_bad_aw
         $error("address width must cover eleven registers");
      end
   endgenerate

   logic          enabled;
   logic          arm_we, fire_we;
   logic          fire_ok;
   logic          clr_pulse;
   logic          at_max;
   logic [CW-1:0] cnt_q;
   logic [KW-1:0] arm_key, fire_key;
   logic          evt_q;
   logic [3:0]    status;

   assign clr_pulse = fire_ok && !evt_q;

   wdt_counter #(.CW(CW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (enabled && fetch_stb && !evt_q),
      .zero     (clr_pulse),
      .max_cnt  (cfg_max_cnt),
      .win_thr  (cfg_win_thr),
      .cnt      (cnt_q),
      .at_max   (at_max),
      .win_open (win_open_o)
   );

   wdt_keyseq #(
      .KW(KW), .BAD_DLY(BAD_DLY), .KEY_ARM(KEY_ARM), .KEY_FIRE(KEY_FIRE)
   ) u_keys (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm_we   (arm_we),
      .fire_we  (fire_we),
      .wdata    (reg_wdata[KW-1:0]),
      .win_open (win_open_o),
      .fire_ok  (fire_ok),
      .arm_key  (arm_key),
      .fire_key (fire_key),
      .bad_pre  (bad_pre_o),
      .bad_clr  (bad_clr_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         evt_q <= 1'b0;
      else
         evt_q <= evt_q | bad_pre_o | bad_clr_o | (enabled && at_max);
   end
   assign evt_o = evt_q;

   always_comb begin
      status             = '0;
      status[ST_BAD_PRE] = bad_pre_o;
      status[ST_BAD_CLR] = bad_clr_o;
      status[ST_EVT]     = evt_q;
      status[ST_WIN]     = win_open_o;
   end

   wdt_regif #(.DW(DW), .CW(CW), .KW(KW), .AW(AW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (reg_we),
      .re       (reg_re),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .force_on (cfg_force_on),
      .cnt      (cnt_q),
      .max_cnt  (cfg_max_cnt),
      .win_thr  (cfg_win_thr),
      .arm_key  (arm_key),
      .fire_key (fire_key),
      .status   (status),
      .rdata    (reg_rdata),
      .enabled  (enabled),
      .arm_we   (arm_we),
      .fire_we  (fire_we)
   );
endmodule

// File: rtl/keyed_window_wdt_chk.sv
module keyed_window_wdt_chk #(
   parameter int CW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          fetch_stb,
   input logic          enabled,
   input logic [CW-1:0] cnt,
   input logic          clr_pulse,
   input logic          evt,
   input logic          bad1,
   input logic          bad2,
   input logic          win
);
   // R1: the count never moves without an enabled strobe or a restart
   a_r1_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_pulse && !(fetch_stb && enabled)) |=> $stable(cnt));
   // R4 / R8: a restart is only honoured while the window is open
   a_r8_clear_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pulse |-> win);
   // R8: an honoured restart zeroes the count
   a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pulse |=> (cnt == '0));
   // R9: sticky flags
   a_r9_evt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> evt);
   a_r9_bad1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      bad1 |=> bad1);
   a_r9_bad2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      bad2 |=> bad2);
   // R11: a fault flag raises the event on the next edge
   a_r11_fault_raises_evt: assert property (@(posedge clk) disable iff (!rst_n)
      (bad1 || bad2) |=> evt);
   // R10: the count is frozen after the event
   a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      evt |=> $stable(cnt));
endmodule

bind keyed_window_wdt keyed_window_wdt_chk #(.CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fetch_stb (fetch_stb),
   .enabled   (enabled),
   .cnt       (cnt_q),
   .clr_pulse (clr_pulse),
   .evt       (evt_o),
   .bad1      (bad_pre_o),
   .bad2      (bad_clr_o),
   .win       (win_open_o)
);

// File: tb/keyed_window_wdt_tb.sv
`timescale 1ns/1ps
module keyed_window_wdt_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_stb = 1'b0;
   logic        cfg_force_on = 1'b1;
   logic [31:0] cfg_max_cnt = 32'd100;
   logic [31:0] cfg_win_thr = 32'd20;
   logic        reg_we = 1'b0;
   logic        reg_re = 1'b0;
   logic [3:0]  reg_addr = 4'd0;
   logic [15:0] reg_wdata = 16'd0;
   logic [15:0] reg_rdata;
   logic        evt_o, bad_pre_o, bad_clr_o, win_open_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   keyed_window_wdt u_dut (
      .clk(clk), .rst_n(rst_n), .fetch_stb(fetch_stb),
      .cfg_force_on(cfg_force_on), .cfg_max_cnt(cfg_max_cnt),
      .cfg_win_thr(cfg_win_thr), .reg_we(reg_we), .reg_re(reg_re),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .evt_o(evt_o), .bad_pre_o(bad_pre_o), .bad_clr_o(bad_clr_o),
      .win_open_o(win_open_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic force_on, input logic [31:0] mx, input logic [31:0] thr);
      @(negedge clk);
      rst_n = 1'b0;
      cfg_force_on = force_on;
      cfg_max_cnt = mx;
      cfg_win_thr = thr;
      fetch_stb = 1'b0;
      reg_we = 1'b0;
      reg_re = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      reg_addr = a;
      reg_wdata = d;
      reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      reg_addr = a;
      reg_re = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_re = 1'b0;
   endtask

   task automatic strobe(input int n);
      if (n > 0) begin
         fetch_stb = 1'b1;
         repeat (n) @(negedge clk);
         fetch_stb = 1'b0;
      end
   endtask

   task automatic rd_cnt(output logic [31:0] c);
      logic [15:0] lo, hi;
      rd(4'd4, lo);
      rd(4'd5, hi);
      c = {hi, lo};
   endtask

   task automatic t_reset_state();
      logic [15:0] d;
      do_reset(1'b0, 32'd100, 32'd20);
      rd(4'd3, d); chk("R9 reset status", d, 16'h0);
      rd(4'd0, d); chk("R3 reset ctrl off", d, 16'h0);
      rd(4'd6, d); chk("R12 reset hold", d, 16'h0);
      rd(4'd4, d); chk("R1 reset count", d, 16'h0);
      chk("R9 reset evt", evt_o, 1'b0);
   endtask

   task automatic t_enable();
      logic [15:0] d;
      logic [31:0] c;
      do_reset(1'b0, 32'd100, 32'd20);
      strobe(3);
      rd_cnt(c); chk("R3 disabled holds", c, 32'd0);
      wr(4'd1, 16'h0033);
      repeat (3) @(negedge clk);
      chk("R3 key ignored while off", bad_pre_o, 1'b0);
      rd(4'd1, d); chk("R3 key reg untouched while off", d, 16'h0);
      wr(4'd0, 16'h0001);
      rd(4'd0, d); chk("R3 software on", d, 16'h1);
      strobe(3);
      rd_cnt(c); chk("R1 count after enable", c, 32'd3);
      wr(4'd0, 16'h0000);
      rd(4'd0, d); chk("R3 write 0 keeps on", d, 16'h1);
      strobe(2);
      rd_cnt(c); chk("R3 still counting", c, 32'd5);
      do_reset(1'b1, 32'd100, 32'd20);
      rd(4'd0, d); chk("R3 forced on reads 1", d, 16'h1);
   endtask

   task automatic t_strobe_gaps();
      logic [31:0] c;
      do_reset(1'b1, 32'd100, 32'd20);
      strobe(4);
      repeat (5) @(negedge clk);
      strobe(1);
      @(negedge clk);
      strobe(2);
      rd_cnt(c); chk("R1 counts strobes only", c, 32'd7);
   endtask

   task automatic t_expire();
      logic [31:0] c;
      do_reset(1'b1, 32'd10, 32'd5);
      strobe(10);
      chk("R2 evt not yet", evt_o, 1'b0);
      @(negedge clk);
      chk("R2 evt at max", evt_o, 1'b1);
      strobe(5);
      rd_cnt(c); chk("R10 count stops at max", c, 32'd10);
      wr(4'd1, 16'h0040);
      wr(4'd2, 16'h0008);
      rd_cnt(c); chk("R10 restart ignored after evt", c, 32'd10);
      chk("R9 evt sticky", evt_o, 1'b1);
   endtask

   task automatic t_window_edge();
      logic [15:0] d;
      logic [31:0] c;
      do_reset(1'b1, 32'd100, 32'd20);
      strobe(19);
      rd(4'd3, d); chk("R4 window closed at thr-1", d[3], 1'b0);
      strobe(1);
      rd(4'd3, d); chk("R4 window open at thr", d[3], 1'b1);
      chk("R4 win output", win_open_o, 1'b1);
      wr(4'd1, 16'h0040);
      rd(4'd1, d); chk("R8 arm key stored", d, 16'h0040);
      wr(4'd2, 16'h0008);
      rd_cnt(c); chk("R8 count zeroed", c, 32'd0);
      rd(4'd1, d); chk("R8 arm key cleared", d, 16'h0);
      rd(4'd2, d); chk("R8 fire key cleared", d, 16'h0);
      repeat (3) @(negedge clk);
      rd(4'd3, d); chk("R8 no fault on valid restart", d, 16'h0);
   endtask

   task automatic t_closed_window();
      do_reset(1'b1, 32'd100, 32'd20);
      strobe(19);
      wr(4'd1, 16'h0040);
      wr(4'd2, 16'h0008);
      repeat (2) @(negedge clk);
      chk("R7 closed window bad_clr", bad_clr_o, 1'b1);
      chk("R7 closed window no bad_pre", bad_pre_o, 1'b0);
      chk("R9 evt from fault", evt_o, 1'b1);
   endtask

   task automatic t_bad_arm_latency();
      logic [31:0] c;
      do_reset(1'b1, 32'd100, 32'd20);
      strobe(5);
      wr(4'd1, 16'h0041);
      chk("R11 flag not at edge k", bad_pre_o, 1'b0);
      @(negedge clk);
      chk("R11 flag at k+1", bad_pre_o, 1'b1);
      chk("R11 evt not at k+1", evt_o, 1'b0);
      @(negedge clk);
      chk("R11 evt at k+2", evt_o, 1'b1);
      chk("R5 wrong arm value only bad_pre", bad_clr_o, 1'b0);
      strobe(3);
      rd_cnt(c); chk("R10 frozen after fault", c, 32'd5);
      repeat (4) @(negedge clk);
      chk("R9 bad_pre sticky", bad_pre_o, 1'b1);
   endtask

   task automatic t_fire_unarmed();
      do_reset(1'b1, 32'd100, 32'd20);
      strobe(25);
      wr(4'd2, 16'h0008);
      repeat (2) @(negedge clk);
      chk("R6 unarmed fire bad_pre", bad_pre_o, 1'b1);
      chk("R6 unarmed fire no bad_clr", bad_clr_o, 1'b0);
   endtask

   task automatic t_bad_fire_value();
      logic [15:0] d;
      do_reset(1'b1, 32'd100, 32'd20);
      strobe(25);
      wr(4'd1, 16'h0040);
      wr(4'd2, 16'h0009);
      repeat (2) @(negedge clk);
      chk("R7 wrong fire bad_clr", bad_clr_o, 1'b1);
      chk("R7 wrong fire no bad_pre", bad_pre_o, 1'b0);
      rd(4'd2, d); chk("R7 wrong fire captured", d, 16'h0009);
   endtask

   task automatic t_double_arm();
      do_reset(1'b1, 32'd100, 32'd20);
      strobe(25);
      wr(4'd1, 16'h0040);
      wr(4'd1, 16'h0040);
      repeat (2) @(negedge clk);
      chk("R7 double arm bad_clr", bad_clr_o, 1'b1);
      chk("R7 double arm no bad_pre", bad_pre_o, 1'b0);
   endtask

   task automatic t_hold_and_cfg();
      logic [15:0] d;
      do_reset(1'b1, 32'h0001_0010, 32'h0001_0000);
      rd(4'd7, d); chk("R13 max lo", d, 16'h0010);
      rd(4'd8, d); chk("R13 max hi", d, 16'h0001);
      rd(4'd9, d); chk("R13 win lo", d, 16'h0000);
      rd(4'd10, d); chk("R13 win hi", d, 16'h0001);
      strobe(32'h0001_0002);
      rd(4'd6, d); chk("R12 hold unchanged without read", d, 16'h0);
      rd(4'd4, d); chk("R1 count lo", d, 16'h0002);
      rd(4'd6, d); chk("R12 hold snapshot", d, 16'h0001);
      chk("R4 window open above thr", win_open_o, 1'b1);
   endtask

   initial begin
      t_reset_state();
      t_enable();
      t_strobe_gaps();
      t_expire();
      t_window_edge();
      t_closed_window();
      t_bad_arm_latency();
      t_fire_unarmed();
      t_bad_fire_value();
      t_double_arm();
      t_hold_and_cfg();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule